// File: doc/BRIEF.md
# Multithreaded In-Order Issue Scheduler

This block is the issue stage of a core running up to eight hardware threads in order. The entry storage is split into one first-in-first-out queue per thread. Each cycle the scheduler looks only at the oldest entry of every queue and decides whether it can issue. It uses a board of pending-write bits indexed by physical register. A physical register number is the thread number placed above the architectural register number, so no renaming happens. One ready head is picked per cycle by rotating priority, and it is presented on a registered issue port.

Results reach the register file late. An execution pipeline reports two things back: a bypass strobe, meaning the value for one physical register can be forwarded in this cycle, and a writeback strobe, meaning the value is now in the register file and its pending bit can be cleared. A pending source that matches the bypass in the current cycle counts as ready. A pending destination always blocks issue until writeback. Each thread has a flush input that discards its queued entries.

Top module: `inorder_issue_sched`

## Requirements
- R1: An entry is 23 bits: bit 22 destination enable, bits 21:18 destination register, bit 17 source-0 enable, bits 16:13 source-0 register, bit 12 source-1 enable, bits 11:8 source-1 register, bits 7:0 tag. Entries of one thread issue strictly in the order they were inserted.
- R2: On issue, the destination and source physical numbers equal thread × 16 + register (thread in bits 6:4, register in bits 3:0).
- R3: An entry whose enabled source has a pending write is held. After `wb_valid` for that register is sampled at an edge, the entry can issue no earlier than the following edge.
- R4: A pending source whose physical number equals `byp_preg` while `byp_valid` is high counts as ready, so the entry issues at that same edge.
- R5: An entry whose enabled destination has a pending write is held until writeback, even if the bypass names that register.
- R6: Issuing an entry with a destination marks that register pending. Only writeback clears the mark; the bypass does not.
- R7: At most one entry issues per edge. Among ready heads, the first thread after the last issuing thread (wrapping past 7 to 0) wins; after reset, thread 0 has top priority.
- R8: `ins_ready[t]` is low while thread t holds QDEPTH (default 4) entries, and an insert into a full queue is dropped.
- R9: `flush[t]` empties thread t's queue at the next edge, blocks any issue from thread t at that edge, drops a same-cycle insert to t, and leaves pending marks unchanged.
- R10: While reset is active and right after it, no entry issues, every `ins_ready` bit is high and no register is pending.
- R11: An entry inserted into an empty queue with no hazard, and with no contention from other threads, appears on the issue port after the second rising edge following the insert cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert strobe |
| ins_tid | input | 3 | Thread receiving the insert |
| ins_data | input | 23 | Entry to insert (layout in R1) |
| ins_ready | output | 8 | Per-thread space available |
| flush | input | 8 | Per-thread queue discard |
| byp_valid | input | 1 | A result is forwardable this cycle |
| byp_preg | input | 7 | Physical register on the bypass |
| wb_valid | input | 1 | A result was written to the register file |
| wb_preg | input | 7 | Physical register written |
| iss_valid | output | 1 | Issue port holds an entry |
| iss_tid | output | 3 | Thread of the issued entry |
| iss_data | output | 23 | Issued entry |
| iss_dst_preg | output | 7 | Physical destination of the issued entry |
| iss_src0_preg | output | 7 | Physical source 0 of the issued entry |
| iss_src1_preg | output | 7 | Physical source 1 of the issued entry |

## Verification
An entry inserted in one cycle is stored at the next rising edge and issued at the edge after that. The bench therefore samples on falling edges, two falling edges after an insert. A writeback sampled at an edge releases a held consumer one edge later, while a bypass releases it at the edge that samples the bypass. Each check is placed at the falling edge that follows the edge on which the result is due, and the cycle before that is checked as well, to show nothing left early. A monitor holds its own copy of the pending marks and reads the issue port just after each rising edge. It uses the bypass and writeback inputs that were applied for that edge, and flags any issue that reads or overwrites a register whose value was not yet available, and any tag that goes backwards within a thread.

// File: rtl/iis_pkg.sv
package iis_pkg;
    localparam int NTHR    = 8;
    localparam int TID_W   = $clog2(NTHR);
    localparam int NREG    = 16;
    localparam int REG_W   = $clog2(NREG);
    localparam int PREG_W  = TID_W + REG_W;
    localparam int NPREG   = NTHR * NREG;
    localparam int TAG_W   = 8;

    typedef struct packed {
        logic             dst_en;
        logic [REG_W-1:0] dst;
        logic             s0_en;
        logic [REG_W-1:0] s0;
        logic             s1_en;
        logic [REG_W-1:0] s1;
        logic [TAG_W-1:0] tag;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);
endpackage

// File: rtl/iis_fifo.sv
module iis_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    input  logic         flush,
    output logic         full,
    output logic         empty,
    output logic [W-1:0] head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [PW:0]             cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (push) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr           = nxt(st_q.wr);
            end
            if (pop) begin
                st_d.rd = nxt(st_q.rd);
            end
            st_d.cnt = st_q.cnt + (PW+1)'(push) - (PW+1)'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full  = (st_q.cnt == (PW+1)'(DEPTH));
    assign empty = (st_q.cnt == '0);
    assign head  = st_q.mem[st_q.rd];

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush) |-> !full);

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);
endmodule

// File: rtl/iis_pend.sv
module iis_pend #(
    parameter int NP = 128,
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [PW-1:0] set_idx,
    input  logic          clr_en,
    input  logic [PW-1:0] clr_idx,
    output logic [NP-1:0] pend
);
    typedef struct packed {
        logic [NP-1:0] bits;
    } pend_st_t;

    pend_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr_en) st_d.bits[clr_idx] = 1'b0;
        if (set_en) st_d.bits[set_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.bits;

    // R6
    mark_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> pend[$past(set_idx)]);

    // R6
    mark_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en && set_idx == clr_idx)) |=> !pend[$past(clr_idx)]);
endmodule

// File: rtl/iis_rr.sv
module iis_rr #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic          gnt_v,
    output logic [IW-1:0] gnt_idx,
    output logic [N-1:0]  gnt_oh
);
    typedef struct packed {
        logic [IW-1:0] last;
    } rr_st_t;

    rr_st_t st_q, st_d;

    always_comb begin
        gnt_v   = 1'b0;
        gnt_idx = '0;
        for (int k = 1; k <= N; k++) begin
            if (!gnt_v && req[(int'(st_q.last) + k) % N]) begin
                gnt_v   = 1'b1;
                gnt_idx = IW'((int'(st_q.last) + k) % N);
            end
        end
        gnt_oh = '0;
        if (gnt_v) gnt_oh[gnt_idx] = 1'b1;
        st_d = st_q;
        if (gnt_v) st_d.last = gnt_idx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{last: IW'(N - 1)};
        else        st_q <= st_d;
    end

    // R7
    grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_v |-> req[gnt_idx]);

    // R7
    grant_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_oh) && (gnt_v == (req != '0)));
endmodule

// File: rtl/inorder_issue_sched.sv
module inorder_issue_sched
    import iis_pkg::*;
#(
    parameter int QDEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ins_valid,
    input  logic [TID_W-1:0]   ins_tid,
    input  logic [INSTR_W-1:0] ins_data,
    output logic [NTHR-1:0]    ins_ready,
    input  logic [NTHR-1:0]    flush,
    input  logic               byp_valid,
    input  logic [PREG_W-1:0]  byp_preg,
    input  logic               wb_valid,
    input  logic [PREG_W-1:0]  wb_preg,
    output logic               iss_valid,
    output logic [TID_W-1:0]   iss_tid,
    output logic [INSTR_W-1:0] iss_data,
    output logic [PREG_W-1:0]  iss_dst_preg,
    output logic [PREG_W-1:0]  iss_src0_preg,
    output logic [PREG_W-1:0]  iss_src1_preg
);
    typedef struct packed {
        logic             v;
        logic [TID_W-1:0] tid;
        instr_t           ins;
    } iss_st_t;

    logic [NTHR-1:0]              q_full, q_empty, rdy, gnt_oh;
    logic [NTHR-1:0][INSTR_W-1:0] head_raw;
    logic [NPREG-1:0]             pend;
    logic                         gnt_v;
    logic [TID_W-1:0]             gnt_idx;
    instr_t                       sel;
    iss_st_t                      iss_q, iss_d;

    for (genvar t = 0; t < NTHR; t++) begin : g_thr
        instr_t            hd;
        logic [PREG_W-1:0] p0, p1, pd;
        logic              ok0, ok1, okd, push_t;

        assign push_t = ins_valid && (ins_tid == TID_W'(t)) && !q_full[t] && !flush[t];

        iis_fifo #(.DEPTH(QDEPTH), .W(INSTR_W)) u_q (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push_t),
            .push_data (ins_data),
            .pop       (gnt_oh[t]),
            .flush     (flush[t]),
            .full      (q_full[t]),
            .empty     (q_empty[t]),
            .head      (head_raw[t])
        );

        assign hd  = instr_t'(head_raw[t]);
        assign p0  = {TID_W'(t), hd.s0};
        assign p1  = {TID_W'(t), hd.s1};
        assign pd  = {TID_W'(t), hd.dst};
        assign ok0 = !hd.s0_en || !pend[p0] || (byp_valid && byp_preg == p0);
        assign ok1 = !hd.s1_en || !pend[p1] || (byp_valid && byp_preg == p1);
        assign okd = !hd.dst_en || !pend[pd];
        assign rdy[t]       = !q_empty[t] && !flush[t] && ok0 && ok1 && okd;
        assign ins_ready[t] = !q_full[t];

        // R9
        flush_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
            flush[t] |=> !(iss_valid && iss_tid == TID_W'(t)));
    end

    iis_rr #(.N(NTHR), .IW(TID_W)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (rdy),
        .gnt_v   (gnt_v),
        .gnt_idx (gnt_idx),
        .gnt_oh  (gnt_oh)
    );

    assign sel = instr_t'(head_raw[gnt_idx]);

    iis_pend #(.NP(NPREG), .PW(PREG_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (gnt_v && sel.dst_en),
        .set_idx ({gnt_idx, sel.dst}),
        .clr_en  (wb_valid),
        .clr_idx (wb_preg),
        .pend    (pend)
    );

    always_comb begin
        iss_d     = iss_q;
        iss_d.v   = gnt_v;
        iss_d.tid = gnt_idx;
        iss_d.ins = sel;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) iss_q <= '0;
        else        iss_q <= iss_d;
    end

    assign iss_valid     = iss_q.v;
    assign iss_tid       = iss_q.tid;
    assign iss_data      = iss_q.ins;
    assign iss_dst_preg  = {iss_q.tid, iss_q.ins.dst};
    assign iss_src0_preg = {iss_q.tid, iss_q.ins.s0};
    assign iss_src1_preg = {iss_q.tid, iss_q.ins.s1};

    // checker state: pending marks and bypass as seen at the issuing edge
    logic [NPREG-1:0]  pend_prev;
    logic              byp_v_prev;
    logic [PREG_W-1:0] byp_prev;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_prev  <= '0;
            byp_v_prev <= 1'b0;
            byp_prev   <= '0;
        end else begin
            pend_prev  <= pend;
            byp_v_prev <= byp_valid;
            byp_prev   <= byp_preg;
        end
    end

    // R3 R4
    src_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_q.ins.s0_en) |->
            (!pend_prev[iss_src0_preg] || (byp_v_prev && byp_prev == iss_src0_preg)));

    // R5
    dst_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_q.ins.dst_en) |-> !pend_prev[iss_dst_preg]);

    // R6
    dst_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_q.ins.dst_en) |-> pend[iss_dst_preg]);
endmodule

// File: tb/tb_inorder_issue_sched.sv
module tb_inorder_issue_sched;
    import iis_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ins_valid = 1'b0;
    logic [TID_W-1:0]   ins_tid = '0;
    logic [INSTR_W-1:0] ins_data = '0;
    logic [NTHR-1:0]    ins_ready;
    logic [NTHR-1:0]    flush = '0;
    logic               byp_valid = 1'b0;
    logic [PREG_W-1:0]  byp_preg = '0;
    logic               wb_valid = 1'b0;
    logic [PREG_W-1:0]  wb_preg = '0;
    logic               iss_valid;
    logic [TID_W-1:0]   iss_tid;
    logic [INSTR_W-1:0] iss_data;
    logic [PREG_W-1:0]  iss_dst_preg, iss_src0_preg, iss_src1_preg;

    always #(CLK_PERIOD/2) clk = ~clk;

    inorder_issue_sched dut (.*);

    int n_chk = 0, n_bad = 0, mon_chk = 0, mon_bad = 0, wd_bad = 0;

    typedef struct packed {
        logic [2:0] tid;
        logic       d_en;
        logic [3:0] d;
        logic       a_en;
        logic [3:0] a;
        logic       b_en;
        logic [3:0] b;
    } vec_t;

    localparam vec_t VT [8] = '{
        '{3'd0, 1'b1, 4'd1,  1'b0, 4'd0,  1'b0, 4'd0},
        '{3'd1, 1'b1, 4'd2,  1'b1, 4'd3,  1'b0, 4'd0},
        '{3'd2, 1'b1, 4'd15, 1'b1, 4'd0,  1'b1, 4'd1},
        '{3'd3, 1'b1, 4'd0,  1'b0, 4'd0,  1'b0, 4'd0},
        '{3'd4, 1'b1, 4'd7,  1'b0, 4'd0,  1'b1, 4'd9},
        '{3'd5, 1'b1, 4'd8,  1'b1, 4'd8,  1'b0, 4'd0},
        '{3'd6, 1'b0, 4'd3,  1'b0, 4'd0,  1'b0, 4'd0},
        '{3'd7, 1'b1, 4'd14, 1'b1, 4'd14, 1'b1, 4'd2}
    };

    function automatic logic [INSTR_W-1:0] mk(input logic de, input int d, input logic ae,
                                              input int a, input logic be, input int b, input int tg);
        instr_t x;
        x.dst_en = de; x.dst = REG_W'(d);
        x.s0_en  = ae; x.s0  = REG_W'(a);
        x.s1_en  = be; x.s1  = REG_W'(b);
        x.tag    = TAG_W'(tg);
        return x;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(); @(negedge clk); endtask

    task automatic do_reset();
        rst_n = 1'b0; ins_valid = 1'b0; flush = '0; byp_valid = 1'b0; wb_valid = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
    endtask

    task automatic put(input int t, input logic [INSTR_W-1:0] d);
        ins_valid = 1'b1; ins_tid = TID_W'(t); ins_data = d;
        step();
        ins_valid = 1'b0;
    endtask

    task automatic wb(input int t, input int r);
        wb_valid = 1'b1; wb_preg = PREG_W'(t * NREG + r);
        step();
        wb_valid = 1'b0;
    endtask

    function automatic int tag_of(input logic [INSTR_W-1:0] d);
        instr_t x; x = instr_t'(d); return int'(x.tag);
    endfunction

    // golden in-order model: pending marks and per-thread tag order
    logic [NPREG-1:0] mdl_pend;
    int               last_tag [NTHR];
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            mdl_pend = '0;
            for (int i = 0; i < NTHR; i++) last_tag[i] = 0;
        end else begin
            if (iss_valid) begin
                instr_t x;
                x = instr_t'(iss_data);
                mon_chk++;
                if (x.s0_en && mdl_pend[iss_src0_preg] && !(byp_valid && byp_preg == iss_src0_preg)) begin
                    mon_bad++;
                    $display("FAIL R3 src0 not available actual=%0d expected=0", iss_src0_preg);
                end
                if (x.s1_en && mdl_pend[iss_src1_preg] && !(byp_valid && byp_preg == iss_src1_preg)) begin
                    mon_bad++;
                    $display("FAIL R4 src1 not available actual=%0d expected=0", iss_src1_preg);
                end
                if (x.dst_en && mdl_pend[iss_dst_preg]) begin
                    mon_bad++;
                    $display("FAIL R5 dst still pending actual=%0d expected=0", iss_dst_preg);
                end
                if (int'(x.tag) <= last_tag[iss_tid]) begin
                    mon_bad++;
                    $display("FAIL R1 order actual=%0d expected>%0d", x.tag, last_tag[iss_tid]);
                end
                last_tag[iss_tid] = int'(x.tag);
            end
            if (wb_valid) mdl_pend[wb_preg] = 1'b0;
            if (iss_valid && iss_data[INSTR_W-1]) mdl_pend[iss_dst_preg] = 1'b1;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        wd_bad = 1;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk + mon_chk + 1, n_bad + mon_bad + 1);
        $finish;
    end

    initial begin
        step();
        do_reset();
        // R10 reset state
        chk("R10 iss_valid", int'(iss_valid), 0);
        chk("R10 ins_ready", int'(ins_ready), 255);

        // table of independent entries: R11 latency, R2 physical numbers
        for (int i = 0; i < 8; i++) begin
            put(VT[i].tid, mk(VT[i].d_en, VT[i].d, VT[i].a_en, VT[i].a, VT[i].b_en, VT[i].b, i + 1));
            chk("R11 not yet", int'(iss_valid), 0);
            step();
            chk("R11 issued", int'(iss_valid), 1);
            chk("R2 tid", int'(iss_tid), int'(VT[i].tid));
            chk("R2 dst preg", int'(iss_dst_preg), VT[i].tid * NREG + VT[i].d);
            chk("R2 src0 preg", int'(iss_src0_preg), VT[i].tid * NREG + VT[i].a);
            chk("R2 src1 preg", int'(iss_src1_preg), VT[i].tid * NREG + VT[i].b);
            chk("R1 tag", tag_of(iss_data), i + 1);
        end

        // R3 source hazard released by writeback
        do_reset();
        put(2, mk(1, 5, 0, 0, 0, 0, 1));
        step();
        chk("R3 producer", int'(iss_valid), 1);
        put(2, mk(1, 6, 1, 5, 0, 0, 2));
        step(); step();
        chk("R3 held", int'(iss_valid), 0);
        wb(2, 5);
        chk("R3 not same edge", int'(iss_valid), 0);
        step();
        chk("R3 released", int'(iss_valid), 1);
        chk("R3 tag", tag_of(iss_data), 2);

        // R4 bypass releases, R6 bypass leaves mark
        do_reset();
        put(3, mk(1, 7, 0, 0, 0, 0, 1));
        step();
        put(3, mk(0, 0, 1, 7, 1, 7, 2));
        step();
        chk("R4 held", int'(iss_valid), 0);
        byp_valid = 1'b1; byp_preg = PREG_W'(3 * NREG + 7);
        step();
        byp_valid = 1'b0;
        chk("R4 bypass issue", int'(iss_valid), 1);
        chk("R4 tag", tag_of(iss_data), 2);
        put(3, mk(0, 0, 1, 7, 0, 0, 3));
        step(); step();
        chk("R6 mark kept", int'(iss_valid), 0);
        wb(3, 7);
        step();
        chk("R6 cleared", int'(iss_valid), 1);

        // R5 destination hazard ignores bypass
        do_reset();
        put(1, mk(1, 4, 0, 0, 0, 0, 1));
        step();
        put(1, mk(1, 4, 0, 0, 0, 0, 2));
        step();
        byp_valid = 1'b1; byp_preg = PREG_W'(1 * NREG + 4);
        step();
        byp_valid = 1'b0;
        chk("R5 held", int'(iss_valid), 0);
        wb(1, 4);
        step();
        chk("R5 released", int'(iss_valid), 1);

        // R7 rotating priority
        do_reset();
        put(0, mk(1, 9, 0, 0, 0, 0, 1));
        put(2, mk(1, 9, 0, 0, 0, 0, 1));
        put(0, mk(0, 0, 1, 9, 0, 0, 2));
        put(0, mk(0, 0, 0, 0, 0, 0, 3));
        put(0, mk(0, 0, 0, 0, 0, 0, 4));
        put(2, mk(0, 0, 1, 9, 0, 0, 2));
        put(2, mk(0, 0, 0, 0, 0, 0, 3));
        step(); step();
        chk("R7 all held", int'(iss_valid), 0);
        wb(0, 9);
        chk("R7 held", int'(iss_valid), 0);
        wb(2, 9);
        begin
            int et [5] = '{0, 2, 0, 2, 0};
            int eg [5] = '{2, 2, 3, 3, 4};
            for (int k = 0; k < 5; k++) begin
                chk("R7 valid", int'(iss_valid), 1);
                chk("R7 thread", int'(iss_tid), et[k]);
                chk("R7 tag", tag_of(iss_data), eg[k]);
                step();
            end
        end
        chk("R7 drained", int'(iss_valid), 0);

        // R8 backpressure and R9 flush
        do_reset();
        put(4, mk(1, 3, 0, 0, 0, 0, 1));
        step();
        for (int k = 2; k <= 5; k++) put(4, mk(0, 0, 1, 3, 0, 0, k));
        chk("R8 full", int'(ins_ready[4]), 0);
        chk("R8 other", int'(ins_ready[3]), 1);
        put(4, mk(0, 0, 0, 0, 0, 0, 6));
        chk("R8 still full", int'(ins_ready[4]), 0);
        flush[4] = 1'b1;
        step();
        flush[4] = 1'b0;
        chk("R9 emptied", int'(ins_ready[4]), 1);
        step(); step();
        chk("R9 nothing left", int'(iss_valid), 0);
        put(4, mk(0, 0, 1, 3, 0, 0, 7));
        step(); step();
        chk("R9 mark kept", int'(iss_valid), 0);
        wb(4, 3);
        step();
        chk("R9 after wb", int'(iss_valid), 1);
        chk("R8 dropped entry", tag_of(iss_data), 7);

        // R9 flush suppresses same-edge issue
        put(6, mk(0, 0, 0, 0, 0, 0, 1));
        flush[6] = 1'b1;
        step();
        flush[6] = 1'b0;
        chk("R9 no issue", int'(iss_valid), 0);
        step();
        chk("R9 gone", int'(iss_valid), 0);

        $display("  test done: total=%0d bad=%0d", n_chk + mon_chk, n_bad + mon_bad + wd_bad);
        $finish;
    end
endmodule